// File: doc/BRIEF.md
# Parity-Checked Byte Bus Master

This block is the host end of a narrow, byte-wide external bus. A host hands it one 64-bit memory request at a time: an address, a write flag, and for writes a data word and a byte-select mask. The block turns the request into a byte stream on an 8-bit output, then listens on an 8-bit input for the responder's acknowledge code and, for reads, the returned data word. Every byte in either direction carries one parity bit that makes the nine bits hold an odd number of ones.

The master launches its bytes on the rising clock edge and captures the responder's bytes on the falling edge. While it waits for the answer it ignores any byte that is not an acknowledge code. It gives up when a programmable number of idle cycles has passed. Each request ends with a one-cycle acknowledge to the host and a two-bit status. A parity fault also raises a sticky flag that stays set until the next request is accepted.

Top module: `bytebus_master`

## Requirements
- R1: After reset the bus output is 0x00 with its parity bit at 1, `rsp_ack` is low and `par_err` is low.
- R2: A write request produces 14 bytes on consecutive cycles: code 0x03, then the four address bytes lowest first, then the select byte, then the eight data bytes lowest first. After the last byte the output returns to 0x00.
- R3: A read request produces 5 bytes on consecutive cycles: code 0x02, then the four address bytes lowest first. The output then returns to 0x00 and stays there while the block is idle.
- R4: Every byte driven on `bus_out`, including idle 0x00, has `bus_out_par` set so that the nine bits hold an odd number of ones.
- R5: For a read, the sequence 0x82 followed at once by eight bytes (lowest first) completes the request with status 00 and those bytes on `rsp_rdata`.
- R6: For a write, a received 0x83 completes the request with status 00 and `rsp_rdata` equal to zero.
- R7: While waiting, any received byte other than 0x82 or 0x83 is ignored, for any number of cycles up to the limit.
- R8: An acknowledge is accepted when it arrives after at most `tmo_limit` idle cycles. After `tmo_limit`+1 idle cycles the request ends with status 01 and zero data. An acknowledge in the cycle that would expire the limit wins.
- R9: A parity fault on any byte received while waiting or during read data ends the request with status 10 and zero data. The fault sets `par_err`, which stays high until the next request is accepted. A parity fault takes priority over every other outcome in that cycle.
- R10: Receiving the acknowledge code of the other command (0x83 after a read, 0x82 after a write) ends the request with status 11 and zero data.
- R11: A request is taken only from idle. Its fields are captured at acceptance, so later changes do not alter the frame. Each request gets exactly one `rsp_ack` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs launch on the rising edge, bus input is captured on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request, held until `rsp_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request address |
| req_wdata | input | 64 | Write data |
| req_sel | input | 8 | Byte-select mask, sent on writes only |
| tmo_limit | input | 16 | Idle cycles tolerated before an acknowledge |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 00 ok, 01 timeout, 10 parity fault, 11 wrong acknowledge |
| rsp_rdata | output | 64 | Read data; zero on writes and on any error |
| par_err | output | 1 | Sticky parity-fault flag |
| bus_out | output | 8 | Byte driven to the responder |
| bus_out_par | output | 1 | Odd-parity bit for `bus_out` |
| bus_in | input | 8 | Byte from the responder |
| bus_in_par | input | 1 | Odd-parity bit for `bus_in` |

## Verification
Two rules can meet in a single waiting cycle. One is the timeout expiring on its last allowed idle cycle. The other is an acknowledge arriving, or a received byte that fails parity. The bench places the acknowledge exactly `tmo_limit` idle cycles after the last request byte, and expects a clean completion. It then places it one cycle later and expects status 01. It also puts bad parity on the acknowledge byte itself, and expects status 10 rather than a normal completion.

// File: rtl/bytebus_master.sv
module bytebus_master #(
  parameter int ADDR_BYTES = 4,
  parameter int DATA_BYTES = 8,
  parameter int TMR_W      = 16,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int DATA_W    = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [7:0]        req_sel,
  input  logic [TMR_W-1:0]  tmo_limit,
  output logic              rsp_ack,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              par_err,
  output logic [7:0]        bus_out,
  output logic              bus_out_par,
  input  logic [7:0]        bus_in,
  input  logic              bus_in_par
);
  localparam int FRAME_BYTES = 2 + ADDR_BYTES + DATA_BYTES;
  localparam int FRAME_W     = 8 * FRAME_BYTES;
  localparam int CNT_W       = $clog2(FRAME_BYTES + 1);
  localparam logic [CNT_W-1:0] WR_LEN   = CNT_W'(FRAME_BYTES);
  localparam logic [CNT_W-1:0] RD_LEN   = CNT_W'(1 + ADDR_BYTES);
  localparam logic [CNT_W-1:0] DATA_LEN = CNT_W'(DATA_BYTES);
  localparam logic [7:0] CODE_RD = 8'h02, CODE_WR = 8'h03;
  localparam logic [7:0] ACK_RD  = 8'h82, ACK_WR  = 8'h83;
  localparam logic [1:0] ST_OK = 2'd0, ST_TMO = 2'd1, ST_PAR = 2'd2, ST_PROT = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RDATA} state_t;

  state_t             st;
  logic [FRAME_W-1:0] tx;
  logic [CNT_W-1:0]   cnt;
  logic [TMR_W-1:0]   tmr;
  logic               wr_q;
  logic [7:0]         in_q;
  logic               in_par_q;

  wire       in_bad   = (in_par_q != ~^in_q);
  wire [7:0] ack_good = wr_q ? ACK_WR : ACK_RD;
  wire [7:0] ack_bad  = wr_q ? ACK_RD : ACK_WR;
  wire       accept   = (st == S_IDLE) && req_valid && !rsp_ack;

  assign bus_out_par = ~^bus_out;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q     <= 8'h00;
      in_par_q <= 1'b1;
    end else begin
      in_q     <= bus_in;
      in_par_q <= bus_in_par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tx         <= '0;
      cnt        <= '0;
      tmr        <= '0;
      wr_q       <= 1'b0;
      bus_out    <= 8'h00;
      rsp_ack    <= 1'b0;
      rsp_status <= ST_OK;
      rsp_rdata  <= '0;
      par_err    <= 1'b0;
    end else begin
      rsp_ack <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          tx        <= {req_wdata, req_sel, req_addr, req_write ? CODE_WR : CODE_RD};
          cnt       <= req_write ? WR_LEN : RD_LEN;
          wr_q      <= req_write;
          rsp_rdata <= '0;
          par_err   <= 1'b0;
          st        <= S_SEND;
        end
        S_SEND: begin
          bus_out <= tx[7:0];
          tx      <= tx >> 8;
          if (cnt == CNT_W'(1)) begin
            st  <= S_WAIT;
            tmr <= '0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_WAIT: begin
          bus_out <= 8'h00;
          if (in_bad) begin
            par_err    <= 1'b1;
            rsp_status <= ST_PAR;
            rsp_ack    <= 1'b1;
            st         <= S_IDLE;
          end else if (in_q == ack_good) begin
            if (wr_q) begin
              rsp_status <= ST_OK;
              rsp_ack    <= 1'b1;
              st         <= S_IDLE;
            end else begin
              cnt <= DATA_LEN;
              st  <= S_RDATA;
            end
          end else if (in_q == ack_bad) begin
            rsp_status <= ST_PROT;
            rsp_ack    <= 1'b1;
            st         <= S_IDLE;
          end else if (tmr == tmo_limit) begin
            rsp_status <= ST_TMO;
            rsp_ack    <= 1'b1;
            st         <= S_IDLE;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        S_RDATA: begin
          if (in_bad) begin
            par_err    <= 1'b1;
            rsp_status <= ST_PAR;
            rsp_rdata  <= '0;
            rsp_ack    <= 1'b1;
            st         <= S_IDLE;
          end else begin
            rsp_rdata <= {in_q, rsp_rdata[DATA_W-1:8]};
            if (cnt == CNT_W'(1)) begin
              rsp_status <= ST_OK;
              rsp_ack    <= 1'b1;
              st         <= S_IDLE;
            end else begin
              cnt <= cnt - CNT_W'(1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (bus_out == 8'h00));

  assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  assert_err_nodata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack && rsp_status != ST_OK) |-> (rsp_rdata == '0));

  assert_par_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !accept) |=> par_err);

  assert_timer_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && $stable(tmo_limit)) |-> (tmr <= tmo_limit));

  assert_parity_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack && rsp_status == ST_PAR) |-> par_err);
endmodule

// File: tb/bytebus_master_tb_top.sv
module bytebus_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_sel = '0;
  logic [15:0] tmo_limit = 16'd20;
  logic        rsp_ack, par_err, bus_out_par;
  logic [1:0]  rsp_status;
  logic [63:0] rsp_rdata;
  logic [7:0]  bus_out;
  logic [7:0]  bus_in = 8'h00;
  logic        bus_in_par = 1'b1;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  bytebus_master dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_sel(req_sel),
    .tmo_limit(tmo_limit), .rsp_ack(rsp_ack), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .par_err(par_err), .bus_out(bus_out),
    .bus_out_par(bus_out_par), .bus_in(bus_in), .bus_in_par(bus_in_par));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic slot();
    @(posedge clk); #1;
  endtask

  task automatic test_reset();
    slot();
    check(bus_out == 8'h00, "R1 bus_out", 64'(bus_out), 0);
    check(bus_out_par == 1'b1, "R1 parity", 64'(bus_out_par), 1);
    check(rsp_ack == 1'b0, "R1 rsp_ack", 64'(rsp_ack), 0);
    check(par_err == 1'b0, "R1 par_err", 64'(par_err), 0);
  endtask

  task automatic run_txn(input bit wr, input logic [31:0] a, input logic [63:0] wd,
                         input logic [7:0] sel, input int dly, input logic [7:0] noise,
                         input logic [7:0] ackc, input bit with_data, input logic [63:0] rdd,
                         input int badi, input logic [1:0] exp_st, input bit chg, input string tag);
    logic [7:0] fr [0:13];
    logic [7:0] rb [0:31];
    int flen, rlen, guard;
    bit got;
    logic [63:0] exp_rd;
    fr[0] = wr ? 8'h03 : 8'h02;
    for (int i = 0; i < 4; i++) fr[1+i] = a[8*i +: 8];
    fr[5] = sel;
    for (int i = 0; i < 8; i++) fr[6+i] = wd[8*i +: 8];
    flen = wr ? 14 : 5;
    rlen = 0;
    for (int i = 0; i < dly; i++) begin rb[rlen] = noise; rlen++; end
    if (ackc != 8'h00) begin rb[rlen] = ackc; rlen++; end
    if (with_data) for (int i = 0; i < 8; i++) begin rb[rlen] = rdd[8*i +: 8]; rlen++; end
    exp_rd = (exp_st == 2'd0 && !wr) ? rdd : 64'h0;

    req_write = wr; req_addr = a; req_wdata = wd; req_sel = sel; req_valid = 1'b1;
    guard = 0;
    do begin slot(); guard++; end while (bus_out == 8'h00 && guard < 8);
    if (chg) begin req_addr = ~a; req_wdata = ~wd; req_sel = ~sel; req_write = ~wr; end
    for (int i = 0; i < flen; i++) begin
      if (i > 0) slot();
      check(bus_out == fr[i], wr ? "R2 frame byte" : "R3 frame byte", 64'(bus_out), 64'(fr[i]));
      check(bus_out_par == ~^bus_out, "R4 out parity", 64'(bus_out_par), 64'(~^bus_out));
    end
    got = 1'b0;
    for (int s = 0; s < rlen + 40 + int'(tmo_limit) && !got; s++) begin
      if (s > 0) slot();
      if (s == 1) begin
        check(bus_out == 8'h00, wr ? "R2 idle after frame" : "R3 idle after frame", 64'(bus_out), 0);
        check(bus_out_par == 1'b1, "R4 idle parity", 64'(bus_out_par), 1);
      end
      if (rsp_ack) begin
        got = 1'b1;
        check(rsp_status == exp_st, {tag, " status"}, 64'(rsp_status), 64'(exp_st));
        check(rsp_rdata == exp_rd, {tag, " rdata"}, rsp_rdata, exp_rd);
        check(par_err == (exp_st == 2'd2), "R9 par_err flag", 64'(par_err), 64'(exp_st == 2'd2));
        req_valid = 1'b0;
        bus_in = 8'h00; bus_in_par = 1'b1;
      end else begin
        bus_in = (s < rlen) ? rb[s] : 8'h00;
        bus_in_par = (s == badi) ? ~(~^bus_in) : ~^bus_in;
      end
    end
    check(got, {tag, " completion seen"}, 64'(got), 1);
    req_valid = 1'b0;
    slot();
    check(rsp_ack == 1'b0, "R11 single ack pulse", 64'(rsp_ack), 0);
    for (int i = 0; i < 3; i++) begin
      slot();
      check(bus_out == 8'h00 && rsp_ack == 1'b0, "R11 no unrequested activity", 64'(bus_out), 0);
    end
  endtask

  task automatic test_write_ok();
    run_txn(1, 32'hA1B2C3D4, 64'h1122334455667788, 8'hF0, 3, 8'h00, 8'h83, 0, 0, -1, 2'd0, 0, "R6 write ok");
  endtask
  task automatic test_read_ok();
    run_txn(0, 32'h00000010, 0, 0, 8, 8'h00, 8'h82, 1, 64'h0102030405060708, -1, 2'd0, 0, "R5 read ok");
  endtask
  task automatic test_noise();
    run_txn(0, 32'hDEADBEEF, 0, 0, 5, 8'h03, 8'h82, 1, 64'hCAFEF00D12345678, -1, 2'd0, 0, "R7 noise ignored");
  endtask
  task automatic test_timeout_edge();
    tmo_limit = 16'd6;
    run_txn(0, 32'h55, 0, 0, 6, 8'h00, 8'h82, 1, 64'h8877665544332211, -1, 2'd0, 0, "R8 ack on last cycle");
    run_txn(0, 32'h55, 0, 0, 7, 8'h00, 8'h82, 1, 64'h8877665544332211, -1, 2'd1, 0, "R8 ack one late");
    run_txn(1, 32'h77, 64'h5, 8'h01, 0, 8'h00, 8'h00, 0, 0, -1, 2'd1, 0, "R8 no ack");
    tmo_limit = 16'd20;
  endtask
  task automatic test_parity();
    run_txn(0, 32'h1234, 0, 0, 2, 8'h00, 8'h82, 1, 64'hFFEEDDCCBBAA9988, 2, 2'd2, 0, "R9 bad ack parity");
    for (int i = 0; i < 3; i++) begin
      slot();
      check(par_err == 1'b1, "R9 sticky", 64'(par_err), 1);
    end
    run_txn(1, 32'h4321, 64'h9, 8'hFF, 1, 8'h00, 8'h83, 0, 0, -1, 2'd0, 0, "R9 clear on next request");
    run_txn(0, 32'h9999, 0, 0, 0, 8'h00, 8'h82, 1, 64'h0011223344556677, 6, 2'd2, 0, "R9 bad data parity");
    run_txn(0, 32'h8888, 0, 0, 4, 8'h00, 8'h82, 1, 64'h1, 1, 2'd2, 0, "R9 bad idle parity");
  endtask
  task automatic test_protocol();
    run_txn(0, 32'h3000, 0, 0, 2, 8'h00, 8'h83, 0, 0, -1, 2'd3, 0, "R10 write ack on read");
    run_txn(1, 32'h3004, 64'h42, 8'h0F, 2, 8'h00, 8'h82, 0, 0, -1, 2'd3, 0, "R10 read ack on write");
  endtask
  task automatic test_hold();
    run_txn(1, 32'h0BADF00D, 64'h0F1E2D3C4B5A6978, 8'hA5, 1, 8'h00, 8'h83, 0, 0, -1, 2'd0, 1, "R11 fields captured");
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_write_ok();
    test_read_ok();
    test_noise();
    test_timeout_edge();
    test_parity();
    test_protocol();
    test_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule